// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a 56-bit physical address by walking a radix tree of page tables held in memory. Pages are 4 KiB, every table is one page of 512 entries of 8 bytes, and the 27-bit virtual page number is consumed nine bits at a time, starting with the most significant slice. A caller presents a virtual address together with the physical page number of the root table. The walker then reads one entry per level over a simple read port and either reports the physical address or raises a fault.

Only one read is in flight at a time. Each entry that comes back is checked for validity. At the two upper levels it must also be a pointer to a further table. The last level supplies the page number of the final page. Any address with a bit set above bit 38 is refused at once, without touching memory. Completion is a single-cycle pulse. The fault flag and the physical address are valid during that pulse.

Top module: `walk3_top`

## Requirements
- R1: A request whose address has any of bits 63 down to 39 set ends with `done` high in the first cycle after acceptance, with `fault` high and no memory read issued.
- R2: Reads follow a fixed address sequence. The first read goes to {rootPpn, va[38:30], 3'b000}. The second goes to {entry[53:10], va[29:21], 3'b000} of the first entry. The third goes to {entry[53:10], va[20:12], 3'b000} of the second entry.
- R3: An entry whose bit 0 (valid) is clear ends the walk with a fault, and no further read is issued. On every fault `pa` reads zero.
- R4: At the two upper levels, an entry with any of bits 3..1 set ends the walk with a fault. At the last level, only bit 0 is examined.
- R5: On success, `pa` equals the last entry's bits 53..10 joined above va[11:0]. Entry bits 63..54 and 9..1 have no effect on the result.
- R6: `memRdValid` and `memRdAddr` hold steady until `memRdReady` is seen, and a new read is never raised before the previous response has arrived.
- R7: `done` is high for exactly one cycle. That cycle is the one following the clock edge at which the completing response was taken.
- R8: `reqReady` is high only while idle. A `reqValid` raised during a walk is ignored and leaves the running walk's result unchanged.
- R9: A synchronous reset returns the walker to idle with no read raised. A response arriving after the reset is ignored.
- R10: A walk that does not fault performs exactly three reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Translation request strobe |
| reqVa | input | 64 | Virtual address to translate |
| rootPpn | input | 44 | Physical page number of the root table |
| reqReady | output | 1 | Walker idle, request will be taken |
| memRdValid | output | 1 | Read request to memory |
| memRdAddr | output | 56 | Byte address of the entry to read |
| memRdReady | input | 1 | Memory accepts the read this cycle |
| memRspValid | input | 1 | Read data returned this cycle |
| memRspData | input | 64 | Returned page table entry |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk failed (valid with done) |
| pa | output | 56 | Translated physical address (valid with done) |

## Verification
An out-of-range request must show `done` at the first falling edge after the edge that took it. Every other walk must show `done` exactly one cycle after the edge that took the last response. The bench keeps a cycle counter and records when each response was presented, so these positions are checked exactly and not merely waited for. The memory responder checks on every stalled cycle that the read address is unchanged. It also checks that the read is withdrawn one cycle after acceptance. After each pulse, the next falling edge must show `done` low.

// File: rtl/walk3_pkg.sv
package walk3_pkg;
  localparam int VA_W          = 64;
  localparam int VA_BITS       = 39;
  localparam int PAGE_BITS     = 12;
  localparam int IDX_BITS      = 9;
  localparam int LEVELS        = 3;
  localparam int PTE_BITS      = 64;
  localparam int FLAG_BITS     = 10;
  localparam int PPN_BITS      = 44;
  localparam int PTE_BYTE_BITS = PAGE_BITS - IDX_BITS;
  localparam int PA_BITS       = PPN_BITS + PAGE_BITS;
  localparam int LVL_W         = $clog2(LEVELS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             descend;
    logic             capture;
    logic [LVL_W-1:0] level;
  } walkCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic vaOutOfRange;
    logic entryValid;
    logic entryPerm;
  } walkSts_t;
endpackage

// File: rtl/walk3_dpath.sv
module walk3_dpath
  import walk3_pkg::*;
#(
  parameter int VaW       = VA_W,
  parameter int VaBits    = VA_BITS,
  parameter int PageBits  = PAGE_BITS,
  parameter int IdxBits   = IDX_BITS,
  parameter int Levels    = LEVELS,
  parameter int PteBits   = PTE_BITS,
  parameter int FlagBits  = FLAG_BITS,
  parameter int PpnBits   = PPN_BITS,
  parameter int PaBits    = PA_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  walkCtl_t           ctl,
  input  logic [VaW-1:0]     reqVa,
  input  logic [PpnBits-1:0] rootPpn,
  input  logic [PteBits-1:0] memRspData,
  output walkSts_t           sts,
  output logic [PaBits-1:0]  memRdAddr,
  output logic [PaBits-1:0]  pa
);
  localparam int ByteBits = PageBits - IdxBits;

  logic [VaW-1:0]     vaQ;
  logic [PpnBits-1:0] baseQ;
  logic [PaBits-1:0]  paQ;
  logic [IdxBits-1:0] idxAt [Levels];
  logic [IdxBits-1:0] idxSel;
  logic [PpnBits-1:0] entryPpn;

  // one index slice per level, level 0 nearest the page offset
  generate
    for (genvar l = 0; l < Levels; l++) begin : g_idx
      assign idxAt[l] = vaQ[PageBits + l*IdxBits +: IdxBits];
    end
  endgenerate

  always_comb begin
    idxSel = '0;
    for (int l = 0; l < Levels; l++) begin
      if (ctl.level == LVL_W'(l)) idxSel = idxAt[l];
    end
  end

  assign entryPpn  = memRspData[FlagBits +: PpnBits];
  assign memRdAddr = {baseQ, idxSel, {ByteBits{1'b0}}};
  assign pa        = paQ;

  assign sts.vaOutOfRange = |reqVa[VaW-1:VaBits];
  assign sts.entryValid   = memRspData[0];
  assign sts.entryPerm    = |memRspData[3:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      vaQ   <= '0;
      baseQ <= '0;
      paQ   <= '0;
    end else begin
      if (ctl.load) begin
        vaQ   <= reqVa;
        baseQ <= rootPpn;
        paQ   <= '0;
      end
      if (ctl.descend) baseQ <= entryPpn;
      if (ctl.capture) paQ <= {entryPpn, vaQ[PageBits-1:0]};
    end
  end
endmodule

// File: rtl/walk3_ctrl.sv
module walk3_ctrl
  import walk3_pkg::*;
#(
  parameter int Levels = LEVELS
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     reqValid,
  input  logic     memRdReady,
  input  logic     memRspValid,
  input  walkSts_t sts,
  output walkCtl_t ctl,
  output logic     reqReady,
  output logic     memRdValid,
  output logic     done,
  output logic     fault
);
  localparam logic [LVL_W-1:0] TopLevel = LVL_W'(Levels - 1);

  walkState_e       stateQ, stateD;
  logic [LVL_W-1:0] levelQ, levelD;
  logic             faultQ, faultD;

  always_comb begin
    stateD    = stateQ;
    levelD    = levelQ;
    faultD    = faultQ;
    ctl       = '0;
    ctl.level = levelQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.load = 1'b1;
          levelD   = TopLevel;
          faultD   = sts.vaOutOfRange;
          stateD   = sts.vaOutOfRange ? ST_DONE : ST_REQ;
        end
      end
      ST_REQ: begin
        if (memRdReady) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (!sts.entryValid || (levelQ != '0 && sts.entryPerm)) begin
            faultD = 1'b1;
            stateD = ST_DONE;
          end else if (levelQ == '0) begin
            ctl.capture = 1'b1;
            stateD      = ST_DONE;
          end else begin
            ctl.descend = 1'b1;
            levelD      = levelQ - LVL_W'(1);
            stateD      = ST_REQ;
          end
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      levelQ <= TopLevel;
      faultQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      levelQ <= levelD;
      faultQ <= faultD;
    end
  end

  assign reqReady   = (stateQ == ST_IDLE);
  assign memRdValid = (stateQ == ST_REQ);
  assign done       = (stateQ == ST_DONE);
  assign fault      = faultQ;
endmodule

// File: rtl/walk3_top.sv
module walk3_top
  import walk3_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic [VA_W-1:0]     reqVa,
  input  logic [PPN_BITS-1:0] rootPpn,
  output logic                reqReady,
  output logic                memRdValid,
  output logic [PA_BITS-1:0]  memRdAddr,
  input  logic                memRdReady,
  input  logic                memRspValid,
  input  logic [PTE_BITS-1:0] memRspData,
  output logic                done,
  output logic                fault,
  output logic [PA_BITS-1:0]  pa
);
  walkCtl_t ctl;
  walkSts_t sts;

  walk3_ctrl #(.Levels(LEVELS)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .reqValid    (reqValid),
    .memRdReady  (memRdReady),
    .memRspValid (memRspValid),
    .sts         (sts),
    .ctl         (ctl),
    .reqReady    (reqReady),
    .memRdValid  (memRdValid),
    .done        (done),
    .fault       (fault)
  );

  walk3_dpath dpath_i (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .reqVa      (reqVa),
    .rootPpn    (rootPpn),
    .memRspData (memRspData),
    .sts        (sts),
    .memRdAddr  (memRdAddr),
    .pa         (pa)
  );
endmodule

// File: rtl/walk3_chk.sv
module walk3_chk
  import walk3_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                reqValid,
  input logic [VA_W-1:0]     reqVa,
  input logic                reqReady,
  input logic                memRdValid,
  input logic [PA_BITS-1:0]  memRdAddr,
  input logic                memRdReady,
  input logic                done,
  input logic                fault,
  input logic [PA_BITS-1:0]  pa
);
  p_oor_fault_r1: assert property (@(posedge clk) disable iff (rst)
    reqReady && reqValid && (|reqVa[VA_W-1:VA_BITS]) |=> done && fault && !memRdValid);

  p_fault_pa_zero_r3: assert property (@(posedge clk) disable iff (rst)
    done && fault |-> pa == '0);

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    memRdValid && !memRdReady |=> memRdValid && $stable(memRdAddr));

  p_single_read_r6: assert property (@(posedge clk) disable iff (rst)
    memRdValid && memRdReady |=> !memRdValid);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> !memRdValid && !done);

  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> reqReady && !memRdValid);
endmodule

bind walk3_top walk3_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .reqValid   (reqValid),
  .reqVa      (reqVa),
  .reqReady   (reqReady),
  .memRdValid (memRdValid),
  .memRdAddr  (memRdAddr),
  .memRdReady (memRdReady),
  .done       (done),
  .fault      (fault),
  .pa         (pa)
);

// File: tb/walk3_top_tb_top.sv
module walk3_top_tb_top;
  import walk3_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [63:0] reqVa = '0;
  logic [43:0] rootPpn = 44'h100;
  logic        reqReady, memRdValid, memRdReady, memRspValid, done, fault;
  logic [55:0] memRdAddr, pa;
  logic [63:0] memRspData;

  always #4 clk = ~clk;

  walk3_top dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqVa(reqVa), .rootPpn(rootPpn),
    .reqReady(reqReady), .memRdValid(memRdValid), .memRdAddr(memRdAddr),
    .memRdReady(memRdReady), .memRspValid(memRspValid), .memRspData(memRspData),
    .done(done), .fault(fault), .pa(pa)
  );

  logic [63:0] memModel [logic [55:0]];
  int          checks = 0;
  int          errors = 0;
  longint      cyc = 0;
  int          rdyDelay = 0;
  int          rspDelay = 1;
  int          readCount = 0;
  longint      lastRspCyc = 0;
  logic [55:0] seenAddr [$];
  logic [55:0] refAddr [3];
  logic        refFault;
  logic [55:0] refPa;
  int          refReads;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [63:0] mkPte(input logic [43:0] ppn, input logic [9:0] flags);
    return {10'h0, ppn, flags};
  endfunction

  // independent walk over the memory model
  task automatic refWalk(input logic [63:0] va, input logic [43:0] root);
    logic [43:0] base;
    logic [63:0] e;
    refFault = 1'b0; refPa = '0; refReads = 0;
    if (|va[63:39]) begin refFault = 1'b1; return; end
    base = root;
    for (int lvl = 2; lvl >= 0; lvl--) begin
      refAddr[refReads] = {base, va[12 + 9*lvl +: 9], 3'b000};
      e = memModel.exists(refAddr[refReads]) ? memModel[refAddr[refReads]] : 64'h0;
      refReads++;
      if (!e[0] || (lvl > 0 && |e[3:1])) begin refFault = 1'b1; return; end
      if (lvl == 0) begin refPa = {e[53:10], va[11:0]}; return; end
      base = e[53:10];
    end
  endtask

  // memory responder
  initial begin : responder
    logic [55:0] a;
    memRdReady = 1'b0; memRspValid = 1'b0; memRspData = '0;
    forever begin
      @(negedge clk);
      if (memRdValid === 1'b1 && !rst) begin
        a = memRdAddr;
        for (int i = 0; i < rdyDelay; i++) begin
          @(negedge clk);
          chk(memRdValid === 1'b1 && memRdAddr === a, "R6", "read held while stalled",
              {8'h0, memRdAddr}, {8'h0, a});
        end
        memRdReady = 1'b1;
        @(negedge clk);
        memRdReady = 1'b0;
        seenAddr.push_back(a);
        readCount++;
        chk(memRdValid === 1'b0, "R6", "no read while response pending", 64'(memRdValid), 64'h0);
        repeat (rspDelay) @(negedge clk);
        memRspValid = 1'b1;
        memRspData  = memModel.exists(a) ? memModel[a] : 64'h0;
        lastRspCyc  = cyc;
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 64'h0, 64'h1);
    finishRun();
  end

  typedef struct packed {
    logic [63:0] va;
    logic        fault;
    logic [1:0]  reads;
    logic [2:0]  kind;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{64'h0000_0000_4040_3456, 1'b0, 2'd3, 3'd0},
    '{64'h0000_0001_4000_0000, 1'b1, 2'd1, 3'd3},
    '{64'h0000_0001_8000_0000, 1'b1, 2'd1, 3'd4},
    '{64'h0000_0000_40E0_0000, 1'b1, 2'd2, 3'd3},
    '{64'h0000_0000_4100_0000, 1'b1, 2'd2, 3'd4},
    '{64'h0000_0000_4040_9000, 1'b1, 2'd3, 3'd3},
    '{64'h0000_007F_FFFF_FFFF, 1'b0, 2'd3, 3'd5},
    '{64'h0000_0080_0000_0000, 1'b1, 2'd0, 3'd1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd0, 3'd1},
    '{64'h0000_0000_0000_0000, 1'b0, 2'd3, 3'd0},
    '{64'h0000_0000_0000_1ABC, 1'b0, 2'd3, 3'd5},
    '{64'h0000_0000_4040_4001, 1'b0, 2'd3, 3'd4}
  };

  function automatic string kindReq(input logic [2:0] k);
    case (k)
      3'd1:    return "R1";
      3'd3:    return "R3";
      3'd4:    return "R4";
      3'd5:    return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic runWalk(input logic [63:0] va, input logic expFault,
                         input int expReads, input string req);
    int startReads;
    int n;
    startReads = readCount;
    seenAddr.delete();
    refWalk(va, rootPpn);
    @(negedge clk);
    reqValid = 1'b1; reqVa = va;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (done !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    chk(done === 1'b1, "R7", "done seen", 64'(done), 64'h1);
    if (expReads == 0)
      chk(n == 0, "R1", "done one cycle after acceptance", 64'(n), 64'h0);
    else
      chk(cyc == lastRspCyc + 1, "R7", "done one cycle after last response",
          64'(cyc), 64'(lastRspCyc + 1));
    chk(fault === refFault, req, "fault vs reference", 64'(fault), 64'(refFault));
    chk(fault === expFault, req, "fault vs table", 64'(fault), 64'(expFault));
    chk(pa === refPa, "R5", "physical address", {8'h0, pa}, {8'h0, refPa});
    chk(readCount - startReads == refReads && refReads == expReads, "R10",
        "read count", 64'(readCount - startReads), 64'(expReads));
    for (int i = 0; i < refReads; i++) begin
      if (i < seenAddr.size())
        chk(seenAddr[i] === refAddr[i], "R2", "entry address", {8'h0, seenAddr[i]}, {8'h0, refAddr[i]});
      else
        chk(1'b0, "R2", "entry address missing", 64'(i), 64'(refReads));
    end
    @(negedge clk);
    chk(done === 1'b0, "R7", "done is a single pulse", 64'(done), 64'h0);
  endtask

  initial begin : stimulus
    int startReads;
    int n;
    bit sawDone;
    // root at page 0x100
    memModel[56'h100000 + 1*8]   = mkPte(44'h200, 10'h001);
    memModel[56'h100000 + 6*8]   = mkPte(44'h400, 10'h003);
    memModel[56'h200000 + 2*8]   = mkPte(44'h300, 10'h001);
    memModel[56'h200000 + 8*8]   = mkPte(44'h310, 10'h009);
    memModel[56'h300000 + 3*8]   = mkPte(44'hABCDE, 10'h007);
    memModel[56'h300000 + 4*8]   = mkPte(44'h77, 10'h001);
    memModel[56'h100000 + 511*8] = mkPte(44'h500, 10'h001);
    memModel[56'h500000 + 511*8] = mkPte(44'h600, 10'h001);
    memModel[56'h600000 + 511*8] = mkPte(44'hFFF_FFFF_FFFF, 10'h00F);
    memModel[56'h100000]         = mkPte(44'h700, 10'h001);
    memModel[56'h700000]         = mkPte(44'h800, 10'h001);
    memModel[56'h800000]         = mkPte(44'h12345, 10'h003);
    memModel[56'h800000 + 8]     = {10'h3FF, 44'h55, 10'h3F1};

    repeat (4) @(negedge clk);
    // R9 reset state
    chk(reqReady === 1'b1, "R9", "reqReady in reset", 64'(reqReady), 64'h1);
    chk(memRdValid === 1'b0, "R9", "no read in reset", 64'(memRdValid), 64'h0);
    chk(done === 1'b0, "R9", "no done in reset", 64'(done), 64'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 12; v++)
      runWalk(VECS[v].va, VECS[v].fault, int'(VECS[v].reads), kindReq(VECS[v].kind));

    // R6 stalled reads and slow responses
    rdyDelay = 3; rspDelay = 4;
    runWalk(VECS[0].va, 1'b0, 3, "R6");
    rdyDelay = 0; rspDelay = 0;
    runWalk(VECS[6].va, 1'b0, 3, "R6");
    rspDelay = 1;

    // R8 request during a walk is ignored
    rspDelay = 3;
    startReads = readCount;
    @(negedge clk);
    reqValid = 1'b1; reqVa = VECS[0].va;
    @(negedge clk);
    reqVa = 64'hFFFF_FFFF_FFFF_FFFF;
    chk(reqReady === 1'b0, "R8", "reqReady low while busy", 64'(reqReady), 64'h0);
    repeat (2) @(negedge clk);
    chk(done === 1'b0, "R8", "busy request not served", 64'(done), 64'h0);
    reqValid = 1'b0;
    n = 0;
    while (done !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    chk(fault === 1'b0, "R8", "running walk result kept", 64'(fault), 64'h0);
    chk(pa === 56'hABCDE456, "R8", "running walk address kept", {8'h0, pa}, 64'hABCDE456);
    chk(readCount - startReads == 3, "R8", "reads of running walk", 64'(readCount - startReads), 64'h3);
    sawDone = 1'b0;
    repeat (4) begin @(negedge clk); if (done === 1'b1) sawDone = 1'b1; end
    chk(!sawDone, "R8", "no second completion", 64'(sawDone), 64'h0);

    // R9 reset in the middle of a walk
    rspDelay = 6;
    startReads = readCount;
    @(negedge clk);
    reqValid = 1'b1; reqVa = VECS[0].va;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (readCount == startReads && n < 50) begin @(negedge clk); n++; end
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(reqReady === 1'b1, "R9", "idle after reset", 64'(reqReady), 64'h1);
    chk(memRdValid === 1'b0, "R9", "no read after reset", 64'(memRdValid), 64'h0);
    sawDone = 1'b0;
    repeat (8) begin @(negedge clk); if (done === 1'b1) sawDone = 1'b1; end
    chk(!sawDone, "R9", "late response ignored", 64'(sawDone), 64'h0);
    chk(memRdValid === 1'b0, "R9", "still idle after late response", 64'(memRdValid), 64'h0);
    rspDelay = 1;
    runWalk(VECS[0].va, 1'b0, 3, "R9");

    finishRun();
  end
endmodule